// File: doc/BRIEF.md
# Sixteen-Channel Interleaved Reed-Solomon Parity Encoder

This block computes systematic Reed-Solomon parity for many independent symbol streams with one shared datapath. Each clock carries the symbol of one channel, and the channels take their turns in a fixed rotation. The encoder has one set of Galois-field constant multipliers and XOR adders. Each remainder register of the classic division circuit is replaced by a delay line as deep as the channel count. A channel's partial remainder therefore travels once around the delay lines and meets that channel's next symbol when it arrives.

Symbols are 8 bits over GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1. Each codeword carries 16 parity symbols, and the generator polynomial has roots alpha^0 to alpha^15. In a message slot the symbol is copied to the output and folded into the remainder. In a parity slot the feedback is gated to zero and the remainder's top stage is shifted out. A start flag on a channel's first message symbol discards that channel's old remainder and leaves every other channel alone. When a cycle carries no symbol, all delay lines hold together.

Top module: `rsx_mch_encoder`

## Requirements
- R1: Reset is synchronous and active high. While reset is held and in the cycle after it is released, out_valid, out_sym and out_chan are 0, and every channel's remainder is zero.
- R2: A cycle with in_valid=1 and in_msg=1 gives, one cycle later, out_valid=1, out_sym equal to that in_sym and out_chan equal to that in_chan.
- R3: The parity slots of a channel are its valid slots with in_msg=0. The first 16 of them that follow the channel's message symbols output, one per slot and one cycle later, the remainder of m(x)*x^16 divided by g(x) = (x+alpha^0)(x+alpha^1)...(x+alpha^15). The x^15 coefficient comes first. Here m(x) has the first message symbol as its highest-degree coefficient, and alpha=2 in the field with polynomial 0x11D.
- R4: Channels that interleave blocks of different lengths with staggered starts do not disturb each other. Every complete codeword on the output (message symbols, then 16 parity symbols) evaluates to zero at alpha^0 through alpha^15.
- R5: A slot with in_start=1 and in_msg=1 treats that channel's old remainder as zero before it takes in the symbol, and changes no other channel. A block left unfinished and restarted with in_start encodes exactly like a fresh block.
- R6: A cycle with in_valid=0 advances no state and gives out_valid=0 one cycle later. The codewords in progress continue unchanged afterwards.
- R7: In a parity slot the message gate feeds zero into the division. Once a channel has had 16 parity slots since its last message symbol, its further parity slots output 0 until its next message symbol.
- R8: Valid cycles carry channels 0,1,...,NCH-1 in strict rotation, starting at 0 after reset. in_chan carries the index of the current slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Slot carries a symbol; 0 stalls every channel |
| in_chan | input | CW ($clog2(NCH)) | Channel index of the current slot |
| in_start | input | 1 | First message symbol of a new block for this channel |
| in_msg | input | 1 | 1 = message symbol, 0 = parity slot |
| in_sym | input | 8 | Message symbol (ignored in parity slots) |
| out_valid | output | 1 | Output symbol valid, one cycle after the slot |
| out_chan | output | CW | Channel of the output symbol |
| out_sym | output | 8 | Message symbol passed through, or parity symbol |

## Verification
The remainder state is visible only through the parity symbols. A corrupted stage, a misaligned delay line or a wrong multiplier constant therefore shows up as a wrong parity symbol in that channel's very next parity phase. The bench compares each symbol on the cycle after its slot. A broken start clear, or leakage between channels, shows up in the first codeword after a restart or in a neighbour's codeword, so restarts and staggered starts are placed throughout the run. Every finished codeword is also checked for zero syndromes, which does not depend on how the bench computes parity.

// File: rtl/rsx_pkg.sv
package rsx_pkg;

    localparam int SYM_W = 8;
    localparam int NPAR  = 16;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

    typedef logic [SYM_W-1:0]         sym_t;
    typedef logic [NPAR:0][SYM_W-1:0] gen_t;

    // Shift-and-add product in GF(2^SYM_W).
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_POLY[SYM_W-1:0];
            else             sh = sh << 1;
        end
        return acc;
    endfunction

    // Generator coefficients, index k = coefficient of x^k, roots alpha^0..alpha^(NPAR-1).
    function automatic gen_t gen_poly();
        gen_t g;
        sym_t root;
        g    = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < NPAR; i++) begin
            for (int k = NPAR; k >= 1; k--) begin
                g[k] = g[k-1] ^ gf_mul(g[k], root);
            end
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, sym_t'(2));
        end
        return g;
    endfunction

endpackage

// File: rtl/rsx_delay_line.sv
module rsx_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] taps [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
        end else if (adv) begin
            taps[0] <= din;
            for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
    end

    // Oldest entry belongs to the channel of the current slot.
    assign dout = taps[DEPTH-1];

endmodule

// File: rtl/rsx_par_stage.sv
module rsx_par_stage import rsx_pkg::*; #(
    parameter sym_t COEF = '0,
    parameter int   NCH  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic clr,
    input  sym_t fb,
    input  sym_t prev,
    output sym_t cur
);

    sym_t head;
    sym_t nxt;

    // A block start hides the stale remainder of this channel only.
    assign cur = clr ? '0 : head;
    assign nxt = prev ^ gf_mul(fb, COEF);

    rsx_delay_line #(
        .W     (SYM_W),
        .DEPTH (NCH)
    ) u_line (
        .clk  (clk),
        .rst  (rst),
        .adv  (adv),
        .din  (nxt),
        .dout (head)
    );

endmodule

// File: rtl/rsx_mch_encoder.sv
module rsx_mch_encoder import rsx_pkg::*; #(
    parameter  int NCH = 16,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [CW-1:0]    in_chan,
    input  logic             in_start,
    input  logic             in_msg,
    input  logic [SYM_W-1:0] in_sym,
    output logic             out_valid,
    output logic [CW-1:0]    out_chan,
    output logic [SYM_W-1:0] out_sym
);

    localparam gen_t GEN = gen_poly();

    typedef struct packed {
        logic          valid;
        logic [CW-1:0] chan;
        sym_t          sym;
    } out_t;

    sym_t eff [NPAR];
    sym_t fb;
    logic clr;
    out_t out_d;
    out_t out_q;

    assign clr = in_start & in_msg;
    // Message gate: feedback only while message symbols enter.
    assign fb  = in_msg ? (in_sym ^ eff[NPAR-1]) : '0;

    for (genvar j = 0; j < NPAR; j++) begin : g_stage
        sym_t prev;
        if (j == 0) begin : g_first
            assign prev = '0;
        end else begin : g_chain
            assign prev = eff[j-1];
        end
        rsx_par_stage #(
            .COEF (GEN[j]),
            .NCH  (NCH)
        ) u_stage (
            .clk  (clk),
            .rst  (rst),
            .adv  (in_valid),
            .clr  (clr),
            .fb   (fb),
            .prev (prev),
            .cur  (eff[j])
        );
    end

    always_comb begin
        out_d.valid = in_valid;
        out_d.chan  = in_chan;
        out_d.sym   = in_msg ? in_sym : eff[NPAR-1];
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign out_chan  = out_q.chan;
    assign out_sym   = out_q.sym;

endmodule

// File: rtl/rsx_mch_encoder_chk.sv
module rsx_mch_encoder_chk import rsx_pkg::*; #(
    parameter  int NCH = 16,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int DW  = $clog2(NPAR + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [CW-1:0]    in_chan,
    input logic             in_msg,
    input logic [SYM_W-1:0] in_sym,
    input logic             out_valid,
    input logic [CW-1:0]    out_chan,
    input logic [SYM_W-1:0] out_sym
);

    logic [CW-1:0] slot_q;
    logic [DW-1:0] drain_q [NCH];
    logic          drained;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            for (int c = 0; c < NCH; c++) drain_q[c] <= DW'(NPAR);
        end else if (in_valid) begin
            slot_q <= (slot_q == CW'(NCH - 1)) ? '0 : slot_q + 1'b1;
            if (in_msg) drain_q[in_chan] <= '0;
            else if (drain_q[in_chan] != DW'(NPAR)) drain_q[in_chan] <= drain_q[in_chan] + 1'b1;
        end
    end

    assign drained = (drain_q[in_chan] == DW'(NPAR));

    AST_CHAN_ORDER: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> in_chan == slot_q); // R8

    AST_MSG_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_msg) |=> (out_valid && out_sym == $past(in_sym))); // R2

    AST_CHAN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_chan == $past(in_chan)); // R2

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R6

    AST_GATE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_msg && drained) |=> out_sym == '0); // R7

endmodule

bind rsx_mch_encoder rsx_mch_encoder_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .in_msg    (in_msg),
    .in_sym    (in_sym),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_sym   (out_sym)
);

// File: tb/sim_rsx_mch_encoder.sv
module sim_rsx_mch_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 16;
    localparam int NP    = 16;
    localparam int STEPS = 7000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_chan  = '0;
    logic       in_start = 1'b0;
    logic       in_msg   = 1'b0;
    logic [7:0] in_sym   = '0;
    logic       out_valid;
    logic [3:0] out_chan;
    logic [7:0] out_sym;

    rsx_mch_encoder #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_start(in_start), .in_msg(in_msg), .in_sym(in_sym),
        .out_valid(out_valid), .out_chan(out_chan), .out_sym(out_sym)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int exp_t [512];
    int log_t [256];
    int gasc  [NP+1];

    // per-channel reference state: 0 idle, 1 message, 2 parity
    int ph [NCH];
    int midx [NCH];
    int pidx [NCH];
    int abort_at [NCH];
    bit must_start [NCH];
    bit restarted [NCH];
    int msgq [NCH][$];
    int obs  [NCH][$];
    int parq [NCH][NP];

    // expectation for the slot driven one cycle earlier: 0 stall, 1 msg, 2 parity, 3 drained
    int pend_kind = -1;
    int pend_ch;
    int pend_sym;
    bit pend_last;
    bit pend_rs;

    function automatic int gmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return exp_t[log_t[a] + log_t[b]];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic build_tables();
        int x;
        x = 1;
        for (int i = 0; i < 255; i++) begin
            exp_t[i] = x;
            exp_t[i+255] = x;
            log_t[x] = i;
            x = x << 1;
            if ((x & 256) != 0) x = x ^ 'h11D;
        end
        for (int k = 0; k <= NP; k++) gasc[k] = 0;
        gasc[0] = 1;
        for (int i = 0; i < NP; i++) begin
            for (int k = NP; k >= 1; k--) gasc[k] = gasc[k-1] ^ gmul(gasc[k], exp_t[i]);
            gasc[0] = gmul(gasc[0], exp_t[i]);
        end
    endtask

    task automatic make_parity(int c);
        int work [64];
        int len;
        int q;
        len = msgq[c].size();
        for (int t = 0; t < 64; t++) work[t] = (t < len) ? msgq[c][t] : 0;
        for (int i = 0; i < len; i++) begin
            q = work[i];
            for (int j = 1; j <= NP; j++) work[i+j] = work[i+j] ^ gmul(q, gasc[NP-j]);
        end
        for (int t = 0; t < NP; t++) parq[c][t] = work[len+t];
    endtask

    task automatic syndrome_check(int c);
        int s;
        for (int i = 0; i < NP; i++) begin
            s = 0;
            foreach (obs[c][k]) s = gmul(s, exp_t[i]) ^ obs[c][k];
            check(s == 0, "R4", $sformatf("syndrome %0d ch %0d", i, c), s, 0);
        end
    endtask

    task automatic sample_prev();
        string rq;
        if (pend_kind < 0) return;
        if (pend_kind == 0) begin
            check(out_valid == 1'b0, "R6", "out_valid after stall", int'(out_valid), 0);
            return;
        end
        check(out_valid == 1'b1, "R2", "out_valid after slot", int'(out_valid), 1);
        check(int'(out_chan) == pend_ch, "R8", "out_chan", int'(out_chan), pend_ch);
        if (pend_kind == 1) rq = "R2";
        else if (pend_kind == 3) rq = "R7";
        else if (pend_rs) rq = "R5";
        else rq = "R3";
        check(int'(out_sym) == pend_sym, rq, $sformatf("out_sym ch %0d", pend_ch), int'(out_sym), pend_sym);
        if (pend_kind == 1 || pend_kind == 2) obs[pend_ch].push_back(int'(out_sym));
        if (pend_last) syndrome_check(pend_ch);
    endtask

    task automatic drive_slot(int c);
        int len;
        in_valid  = 1'b1;
        in_chan   = 4'(c);
        in_start  = 1'b0;
        pend_ch   = c;
        pend_last = 1'b0;
        if (ph[c] == 0 && (must_start[c] || ($urandom % 4) == 0)) begin
            len = 1 + int'($urandom % 24);
            msgq[c].delete();
            obs[c].delete();
            for (int i = 0; i < len; i++) msgq[c].push_back(int'($urandom % 256));
            abort_at[c] = (len > 2 && ($urandom % 5) == 0) ? 1 + int'($urandom % (len - 1)) : -1;
            restarted[c] = must_start[c];
            must_start[c] = 1'b0;
            ph[c] = 1;
            midx[c] = 0;
        end
        pend_rs = restarted[c];
        if (ph[c] == 0) begin
            in_msg = 1'b0;
            in_sym = 8'($urandom);
            pend_kind = 3;
            pend_sym = 0;
        end else if (ph[c] == 1) begin
            in_msg   = 1'b1;
            in_start = (midx[c] == 0);
            in_sym   = 8'(msgq[c][midx[c]]);
            pend_kind = 1;
            pend_sym = msgq[c][midx[c]];
            midx[c]++;
            if (midx[c] == abort_at[c]) begin
                ph[c] = 0;
                must_start[c] = 1'b1;
            end else if (midx[c] == msgq[c].size()) begin
                make_parity(c);
                ph[c] = 2;
                pidx[c] = 0;
            end
        end else begin
            in_msg = 1'b0;
            in_sym = 8'($urandom);
            pend_kind = 2;
            pend_sym = parq[c][pidx[c]];
            pidx[c]++;
            if (pidx[c] == NP) begin
                ph[c] = 0;
                pend_last = 1'b1;
            end
        end
    endtask

    initial begin
        int ch;
        build_tables();
        for (int c = 0; c < NCH; c++) begin
            ph[c] = 0; midx[c] = 0; pidx[c] = 0; abort_at[c] = -1;
            must_start[c] = 1'b0; restarted[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_sym == 8'h00, "R1", "out_sym in reset", int'(out_sym), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_chan == 4'h0, "R1", "out_chan after reset", int'(out_chan), 0);
        ch = 0;
        for (int step = 0; step < STEPS; step++) begin
            sample_prev();
            if (($urandom % 8) == 0) begin
                in_valid = 1'b0;
                in_start = 1'b0;
                in_msg   = 1'b1;
                in_sym   = 8'($urandom);
                pend_kind = 0;
                pend_last = 1'b0;
            end else begin
                drive_slot(ch);
                ch = (ch + 1) % NCH;
            end
            @(negedge clk);
        end
        sample_prev();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule